// File: doc/BRIEF.md
# Processor Interrupt Level Selector

This block sits in front of a processor core and decides, every clock, whether the core should be asked to take an interrupt and with which trap type. Three sources feed it. The first is a 16-bit vector of external interrupt levels. The second is a software-interrupt register whose two timer-match bits both count as level 14. The third is a vectored-interrupt line that carries an interrupt number.

The core supplies its current interrupt level, a global enable, its trap nesting depth and the trap type of the innermost active trap. From these the block picks the highest pending level above the current level. It also holds back a new request while a higher-numbered external-interrupt trap is still being handled.

A vectored interrupt outranks every level interrupt. While one is pending, level evaluation is frozen. The block latches a data word that holds a fixed tag and the interrupt number. The request, trap type and data word are all registered, so each one reflects the inputs seen at the previous rising clock edge.

Top module: `irq_level_select`

## Requirements
- R1: After reset, `irq_req_o` is 0, `trap_type_o` is 0 and `vec_data_o` is 0.
- R2: The level vector is formed as `lvl_in` OR `swint_in[15:0]` with bit 0 cleared. Level 14 is added when timer-match bit 0 or timer-match bit 16 of `swint_in` is set.
- R3: With no vector pending, if no level above `pil_in` is set, then one cycle later `irq_req_o` is 0 and `trap_type_o` is 0.
- R4: With no vector pending, interrupts enabled and a level above `pil_in` set, the highest such level L is selected. One cycle later `trap_type_o` is 0x040 OR L and `irq_req_o` is 1, unless R6 applies.
- R5: With no vector pending and `ie_in` low, one cycle later `irq_req_o` is 0 and `trap_type_o` is 0, whatever levels are set.
- R6: Suppose `tl_in` is nonzero, `cur_tt_in[8:4]` equals 4 (an external-interrupt trap), and `cur_tt_in` is greater than the newly selected type. Then `irq_req_o` and `trap_type_o` keep their values.
- R7: Suppose `vec_lvl_in` is high and no vector is pending. One cycle later the block marks a vector pending, `irq_req_o` is 1 and `trap_type_o` is 0x060. `vec_data_o` is then `{5'h1F, vec_num_in}`, which is 0x7C0 OR the number.
- R8: While a vector is pending and `vec_lvl_in` stays high, the level, software, level, enable and trap inputs are ignored. `irq_req_o`, `trap_type_o` and `vec_data_o` hold.
- R9: When `vec_lvl_in` is low while a vector is pending, the pending mark clears and one cycle later `irq_req_o` is 0. `trap_type_o` and `vec_data_o` hold for that cycle, and level evaluation resumes from the next cycle.
- R10: Every output change appears exactly one clock after the input values that cause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_in | input | 16 | External interrupt levels, bit i is level i |
| swint_in | input | 17 | Software-interrupt register; bits 0 and 16 are timer-match bits |
| pil_in | input | 4 | Current processor interrupt level |
| ie_in | input | 1 | Global interrupt enable |
| tl_in | input | 3 | Current trap nesting level |
| cur_tt_in | input | 9 | Trap type of the innermost active trap |
| vec_lvl_in | input | 1 | Vectored-interrupt line level |
| vec_num_in | input | 6 | Vectored-interrupt number |
| irq_req_o | output | 1 | Interrupt request to the core |
| trap_type_o | output | 9 | Trap type to take |
| vec_data_o | output | 11 | Captured vector data word |

## Verification
Directed patterns each isolate one merge or priority effect:
- a lone timer-match bit, on either position, must yield level 14;
- a software bit 0 must be ignored;
- `pil_in` at 15 must block every level;
- a level equal to `pil_in` must not win over nothing.

Nesting cases place an external trap type just above, equal to and below the new type. These separate the strict compare and the upper-bit match from a plain trap-level test.

Random sequences with a fixed seed mix sparse level vectors and occasional vector pulses. They catch a vector rising in the same cycle as level changes, a vector dropping while levels are pending, and the enable toggling while a request is outstanding. Each of these yields a different expected type, request and data word.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int NLVL   = 16;
  localparam int LW     = $clog2(NLVL);
  localparam int TTW    = 9;
  localparam int VNW    = 6;
  localparam int TAGW   = 5;
  localparam int VDW    = TAGW + VNW;
  localparam int TMR_LVL = NLVL - 2;

  localparam logic [TTW-1:0]  EXT_BASE = 9'h040;
  localparam logic [TTW-1:0]  VEC_TT   = 9'h060;
  localparam logic [TAGW-1:0] VEC_TAG  = 5'h1F;

  function automatic logic [TTW-1:0] f_ext_tt(input logic [LW-1:0] lvl);
    f_ext_tt = EXT_BASE | TTW'(lvl);
  endfunction

  function automatic logic [VDW-1:0] f_vec_word(input logic [VNW-1:0] num);
    f_vec_word = {VEC_TAG, num};
  endfunction

  function automatic logic f_is_ext(input logic [TTW-1:0] tt);
    f_is_ext = (tt[TTW-1:4] == EXT_BASE[TTW-1:4]);
  endfunction
endpackage

// File: rtl/irqsel_merge.sv
module irqsel_merge
  import irqsel_pkg::*;
#(
  parameter int NL = NLVL,
  parameter int TL = TMR_LVL
) (
  input  logic [NL-1:0] lvl_in,
  input  logic [NL:0]   swint_in,
  output logic [NL-1:0] pend_o,
  output logic          timer_hit_o
);
  logic [NL-1:0] sw_lv;
  logic [NL-1:0] tmr_vec;

  assign timer_hit_o = swint_in[0] | swint_in[NL];
  assign sw_lv       = swint_in[NL-1:0] & ~NL'(1);
  assign tmr_vec     = timer_hit_o ? (NL'(1) << TL) : '0;
  assign pend_o      = lvl_in | sw_lv | tmr_vec;
endmodule

// File: rtl/irqsel_prio.sv
module irqsel_prio
  import irqsel_pkg::*;
#(
  parameter int NL = NLVL,
  localparam int W = $clog2(NL)
) (
  input  logic [NL-1:0] pend_i,
  input  logic [W-1:0]  pil_i,
  output logic          any_o,
  output logic [W-1:0]  sel_o
);
  logic [NL-1:0] above;

  for (genvar i = 0; i < NL; i++) begin : g_mask
    assign above[i] = pend_i[i] && (W'(i) > pil_i);
  end

  assign any_o = |above;

  always_comb begin
    sel_o = '0;
    for (int i = 0; i < NL; i++) begin
      if (above[i]) sel_o = W'(i);
    end
  end
endmodule

// File: rtl/irqsel_nest.sv
module irqsel_nest
  import irqsel_pkg::*;
#(
  parameter int TLW = 3
) (
  input  logic [TLW-1:0] tl_i,
  input  logic [TTW-1:0] cur_tt_i,
  input  logic [TTW-1:0] new_tt_i,
  output logic           block_o
);
  assign block_o = (tl_i != '0) && f_is_ext(cur_tt_i) && (cur_tt_i > new_tt_i);
endmodule

// File: rtl/irq_level_select.sv
module irq_level_select
  import irqsel_pkg::*;
#(
  parameter int TLW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLVL-1:0]   lvl_in,
  input  logic [NLVL:0]     swint_in,
  input  logic [LW-1:0]     pil_in,
  input  logic              ie_in,
  input  logic [TLW-1:0]    tl_in,
  input  logic [TTW-1:0]    cur_tt_in,
  input  logic              vec_lvl_in,
  input  logic [VNW-1:0]    vec_num_in,
  output logic              irq_req_o,
  output logic [TTW-1:0]    trap_type_o,
  output logic [VDW-1:0]    vec_data_o
);
  logic [NLVL-1:0] pend_vec;
  logic            timer_hit;
  logic            lvl_any;
  logic [LW-1:0]   lvl_sel;
  logic [TTW-1:0]  new_tt;
  logic            nest_block;

  logic            pend_q, pend_d;
  logic            req_d;
  logic [TTW-1:0]  tt_d;
  logic [VDW-1:0]  data_d;

  logic            vec_rise, vec_fall, vec_hold, lvl_fire;

  irqsel_merge #(.NL(NLVL), .TL(TMR_LVL)) u_merge (
    .lvl_in(lvl_in), .swint_in(swint_in),
    .pend_o(pend_vec), .timer_hit_o(timer_hit)
  );

  irqsel_prio #(.NL(NLVL)) u_prio (
    .pend_i(pend_vec), .pil_i(pil_in),
    .any_o(lvl_any), .sel_o(lvl_sel)
  );

  assign new_tt = f_ext_tt(lvl_sel);

  irqsel_nest #(.TLW(TLW)) u_nest (
    .tl_i(tl_in), .cur_tt_i(cur_tt_in), .new_tt_i(new_tt),
    .block_o(nest_block)
  );

  assign vec_rise = vec_lvl_in && !pend_q;
  assign vec_fall = !vec_lvl_in && pend_q;
  assign vec_hold = vec_lvl_in && pend_q;
  assign lvl_fire = !vec_lvl_in && !pend_q && ie_in && lvl_any && !nest_block;

  always_comb begin
    pend_d = pend_q;
    req_d  = irq_req_o;
    tt_d   = trap_type_o;
    data_d = vec_data_o;
    if (vec_rise) begin
      pend_d = 1'b1;
      req_d  = 1'b1;
      tt_d   = VEC_TT;
      data_d = f_vec_word(vec_num_in);
    end else if (vec_fall) begin
      pend_d = 1'b0;
      req_d  = 1'b0;
    end else if (vec_hold) begin
      pend_d = 1'b1;
    end else if (!lvl_any || !ie_in) begin
      req_d = 1'b0;
      tt_d  = '0;
    end else if (lvl_fire) begin
      req_d = 1'b1;
      tt_d  = new_tt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      irq_req_o   <= 1'b0;
      trap_type_o <= '0;
      vec_data_o  <= '0;
    end else begin
      pend_q      <= pend_d;
      irq_req_o   <= req_d;
      trap_type_o <= tt_d;
      vec_data_o  <= data_d;
    end
  end
endmodule

// File: rtl/irqsel_chk.sv
module irqsel_chk
  import irqsel_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           pend_q,
  input logic           vec_lvl_in,
  input logic [VNW-1:0] vec_num_in,
  input logic           ie_in,
  input logic           lvl_any,
  input logic           nest_block,
  input logic           irq_req_o,
  input logic [TTW-1:0] trap_type_o,
  input logic [VDW-1:0] vec_data_o
);
  assert_vec_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_lvl_in && !pend_q) |=> (irq_req_o && trap_type_o == VEC_TT
      && vec_data_o == {VEC_TAG, $past(vec_num_in)}));

  assert_vec_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_lvl_in && pend_q) |=> ($stable(irq_req_o) && $stable(trap_type_o)
      && $stable(vec_data_o)));

  assert_vec_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_lvl_in && pend_q) |=> (!irq_req_o && $stable(trap_type_o)));

  assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_lvl_in && !pend_q && !ie_in) |=> (!irq_req_o && trap_type_o == '0));

  assert_none_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_lvl_in && !pend_q && !lvl_any) |=> (!irq_req_o && trap_type_o == '0));

  assert_nest_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_lvl_in && !pend_q && ie_in && lvl_any && nest_block)
      |=> ($stable(trap_type_o) && $stable(irq_req_o)));

  assert_req_typed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (trap_type_o != '0));
endmodule

bind irq_level_select irqsel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .vec_lvl_in(vec_lvl_in),
  .vec_num_in(vec_num_in), .ie_in(ie_in), .lvl_any(lvl_any),
  .nest_block(nest_block), .irq_req_o(irq_req_o),
  .trap_type_o(trap_type_o), .vec_data_o(vec_data_o)
);

// File: tb/tb_irq_level_select.sv
`timescale 1ns/1ps
module tb_irq_level_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lvl_in = '0;
  logic [16:0] swint_in = '0;
  logic [3:0]  pil_in = '0;
  logic        ie_in = 1'b0;
  logic [2:0]  tl_in = '0;
  logic [8:0]  cur_tt_in = '0;
  logic        vec_lvl_in = 1'b0;
  logic [5:0]  vec_num_in = '0;
  logic        irq_req_o;
  logic [8:0]  trap_type_o;
  logic [10:0] vec_data_o;

  int total = 0;
  int bad = 0;

  // model state
  bit       m_pend = 0;
  bit       m_req = 0;
  int       m_tt = 0;
  int       m_data = 0;
  string    m_tag = "R1";

  always #5 clk = ~clk;

  irq_level_select dut (
    .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .swint_in(swint_in),
    .pil_in(pil_in), .ie_in(ie_in), .tl_in(tl_in), .cur_tt_in(cur_tt_in),
    .vec_lvl_in(vec_lvl_in), .vec_num_in(vec_num_in),
    .irq_req_o(irq_req_o), .trap_type_o(trap_type_o), .vec_data_o(vec_data_o)
  );

  // R2: merged level word
  function automatic int merged(input int lv, input int sw);
    int p;
    p = lv | (sw & 32'h0000_FFFE);
    if ((sw & 32'h0001_0001) != 0) p = p | (1 << 14);
    return p;
  endfunction

  function automatic int top_bit(input int p);
    for (int i = 15; i >= 0; i--) if (((p >> i) & 1) == 1) return i;
    return -1;
  endfunction

  task automatic model_step();
    int p, lvl, ntt, ctt;
    p   = merged(int'(lvl_in), int'(swint_in));
    ctt = int'(cur_tt_in);
    if (vec_lvl_in && !m_pend) begin
      m_pend = 1; m_req = 1; m_tt = 'h60; m_data = 'h7C0 | int'(vec_num_in); m_tag = "R7";
    end else if (!vec_lvl_in && m_pend) begin
      m_pend = 0; m_req = 0; m_tag = "R9";
    end else if (m_pend) begin
      m_tag = "R8";
    end else if (p < (2 << pil_in)) begin
      m_req = 0; m_tt = 0; m_tag = "R3";
    end else if (!ie_in) begin
      m_req = 0; m_tt = 0; m_tag = "R5";
    end else begin
      lvl = top_bit(p);
      ntt = 'h40 + lvl;
      if (tl_in != 0 && (ctt >> 4) == 4 && ctt > ntt) m_tag = "R6";
      else begin m_req = 1; m_tt = ntt; m_tag = "R4"; end
    end
  endtask

  task automatic compare(input string tag);
    total++;
    if (irq_req_o !== m_req || int'(trap_type_o) != m_tt || int'(vec_data_o) != m_data) begin
      bad++;
      $display("FAIL %s R10: req=%0d tt=%03h data=%03h expected req=%0d tt=%03h data=%03h",
               tag, irq_req_o, trap_type_o, vec_data_o, m_req, m_tt, m_data);
    end
  endtask

  // inputs already set; one clock later (R10) outputs compared at negedge
  task automatic step();
    model_step();
    @(negedge clk);
    compare(m_tag);
  endtask

  task automatic setl(input logic [15:0] l, input logic [16:0] s, input logic [3:0] p,
                      input logic e, input logic [2:0] t, input logic [8:0] c);
    lvl_in = l; swint_in = s; pil_in = p; ie_in = e; tl_in = t; cur_tt_in = c;
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    m_tag = "R1";
    compare("R1");           // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: timer bit 0 alone -> level 14
    setl(16'h0, 17'h00001, 4'd0, 1, 3'd0, 9'h0); step();
    // R2: timer bit 16 alone -> level 14
    setl(16'h0, 17'h10000, 4'd3, 1, 3'd0, 9'h0); step();
    // R2: software bit 0 ignored as level
    setl(16'h0, 17'h00000, 4'd0, 1, 3'd0, 9'h0); step();
    setl(16'h0001, 17'h00000, 4'd0, 1, 3'd0, 9'h0); step();
    // R2 soft level 9
    setl(16'h0, 17'h00200, 4'd2, 1, 3'd0, 9'h0); step();
    // R3: pil 15 blocks all
    setl(16'hFFFF, 17'h1FFFF, 4'd15, 1, 3'd0, 9'h0); step();
    // R3: level equals pil
    setl(16'h0020, 17'h0, 4'd5, 1, 3'd0, 9'h0); step();
    // R4: highest above pil
    setl(16'h0821, 17'h0, 4'd5, 1, 3'd0, 9'h0); step();
    // R5: disabled while outstanding
    setl(16'h0821, 17'h0, 4'd5, 0, 3'd0, 9'h0); step();
    // R6: nesting compare, just above / equal / below
    setl(16'h0100, 17'h0, 4'd0, 1, 3'd0, 9'h0); step();
    setl(16'h0400, 17'h0, 4'd0, 1, 3'd1, 9'h04B); step();   // hold (R6)
    setl(16'h0400, 17'h0, 4'd0, 1, 3'd1, 9'h04A); step();   // equal -> R4
    setl(16'h0800, 17'h0, 4'd0, 1, 3'd1, 9'h04A); step();   // below -> R4
    setl(16'h0100, 17'h0, 4'd0, 1, 3'd1, 9'h05F); step();   // not external -> R4
    setl(16'h0100, 17'h0, 4'd0, 1, 3'd0, 9'h04F); step();   // tl 0 -> R4
    // R7/R8/R9 vector sequence
    vec_num_in = 6'd37; vec_lvl_in = 1; step();
    setl(16'hFFFF, 17'h0, 4'd0, 0, 3'd0, 9'h0); vec_num_in = 6'd5; step(); // R8
    step();
    vec_lvl_in = 0; setl(16'h8000, 17'h0, 4'd0, 1, 3'd0, 9'h0); step();   // R9
    step();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom;
      lvl_in   = (r[1:0] == 0) ? 16'h0 : 16'($urandom) & 16'($urandom);
      swint_in = (r[3:2] == 0) ? 17'($urandom) : 17'h0;
      pil_in   = 4'($urandom);
      ie_in    = (r[6:4] != 0);
      tl_in    = (r[8:7] == 0) ? 3'($urandom) : 3'd0;
      cur_tt_in = r[9] ? (9'h040 | 9'($urandom % 16)) : 9'($urandom);
      if (r[15:12] == 0) vec_lvl_in = ~vec_lvl_in;
      vec_num_in = 6'($urandom);
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule